// File: doc/BRIEF.md
# Block-Lock Write Protection Guard

This block sits between a serial memory's command decoder and its nonvolatile array. It judges every write request before the write reaches storage. It holds an 8-bit protection register. Each request carries a 12-bit word address, a data byte and the level of the hardware write-protect pin. One clock after the request, the block either grants the array write or raises a one-cycle reject pulse.

The protection has three layers:

- **Write-enable latch.** A latch bit in the register must be set before any array write is granted.
- **Block protection.** A two-bit code locks a region that always reaches down from the top address. The code can lock nothing, the top quarter, the top half or the whole array.
- **Hardware freeze.** While the pin is high and the hardware-enable bit is set, the register itself is frozen.

The register shares the top address of the array. A write to that address loads the register and never reaches the array. The register resets to a parameterised power-on value.

Top module: `blocklock_guard`

## Requirements
- R1: After reset, `prot_reg` equals the power-on value with only bits 7, 4, 3 and 1 kept (default 0x00), and `arr_wr_ok` and `wr_reject` are low.
- R2: An array write (address not 0xFFF) is refused while the latch bit (bit 1 of `prot_reg`) is 0.
- R3: The lock code in bits 4:3 of `prot_reg` locks these regions:
  - 00 locks nothing.
  - 01 locks 0xC00 to 0xFFF.
  - 10 locks 0x800 to 0xFFF.
  - 11 locks every address.

  An array write into a locked region is refused even when the latch bit is set.
- R4: An array write outside the locked region with the latch bit set gives a one-cycle `arr_wr_ok` pulse in the cycle after the request, and `wr_reject` stays low.
- R5: A write to address 0xFFF targets the register only. When accepted, it loads `prot_reg` with the data byte ANDed with 0x9A, visible in the cycle after the request. The kept bits are bit 7 (hardware-enable), bits 4:3 (lock code) and bit 1 (latch); every other bit reads 0. Neither `arr_wr_ok` nor `wr_reject` pulses for an accepted register write.
- R6: While `wp_pin` is high and bit 7 of `prot_reg` is 1, a register write is refused:
  - `wr_reject` pulses for one cycle.
  - `prot_reg` keeps its value.
- R7: While `wp_pin` is low, register writes are accepted whatever the value of bit 7.
- R8: The latch bit can be set or cleared by a register write even while the lock code is 11, provided the register is not frozen.
- R9: `arr_wr_ok` and `wr_reject` are never high together. Either one is high only in the cycle after a request, and both are low in any cycle after a cycle without a request.
- R10: A refused write of any kind leaves `prot_reg` unchanged. The register changes only in the cycle after an accepted register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request valid this cycle |
| wr_addr | input | 12 | Target word address of the request |
| wr_data | input | 8 | Data byte of the request |
| wp_pin | input | 1 | Hardware write-protect pin level |
| arr_wr_ok | output | 1 | One-cycle grant of an array write |
| wr_reject | output | 1 | One-cycle pulse for a refused write |
| prot_reg | output | 8 | Current protection register contents |

## Verification
The bench walks the lock code through all four settings. For each setting it writes just below and exactly on the region boundary (0xBFF/0xC00, 0x7FF/0x800). A decoder off by one row, or one that grows the region upward, would grant or refuse the wrong side.

It freezes the register with the pin high, then tries to unfreeze it. It then drops the pin and rewrites the register. A design that ignored the pin, or that let a frozen write through, would show a changed register or a missing reject.

It also covers these cases:
- It clears the latch bit while the whole array is locked. A design that gated register writes on the array rules would keep the stale latch.
- It writes 0xFF to the register. Unused bits that leaked through would appear in `prot_reg`.

// File: rtl/blocklock_pkg.sv
package blocklock_pkg;

  localparam int REG_W    = 8;
  localparam int LATCH_B  = 1;
  localparam int LOCK_LO  = 3;
  localparam int LOCK_HI  = 4;
  localparam int HWEN_B   = 7;

  localparam logic [REG_W-1:0] KEEP_MASK =
    (REG_W'(1) << LATCH_B) | (REG_W'(1) << LOCK_LO) |
    (REG_W'(1) << LOCK_HI) | (REG_W'(1) << HWEN_B);

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_code_e;

  typedef struct packed {
    logic arr_ok;
    logic reg_ok;
    logic refuse;
  } verdict_t;

  function automatic logic [REG_W-1:0] clean_reg(input logic [REG_W-1:0] raw);
    return raw & KEEP_MASK;
  endfunction

  function automatic lock_code_e lock_of(input logic [REG_W-1:0] r);
    return lock_code_e'(r[LOCK_HI:LOCK_LO]);
  endfunction

  function automatic logic latch_of(input logic [REG_W-1:0] r);
    return r[LATCH_B];
  endfunction

  function automatic logic frozen(input logic pin, input logic [REG_W-1:0] r);
    return pin & r[HWEN_B];
  endfunction

endpackage

// File: rtl/blocklock_region.sv
module blocklock_region
  import blocklock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  lock_code_e        code,
  output logic              in_lock
);

  localparam int TOP = ADDR_W - 1;

  // Regions grow downward from the highest address: the quarter region is
  // marked by the two top address bits both set, the half by the top bit.
  always_comb begin
    unique case (code)
      LOCK_NONE:    in_lock = 1'b0;
      LOCK_QUARTER: in_lock = addr[TOP] & addr[TOP-1];
      LOCK_HALF:    in_lock = addr[TOP];
      LOCK_ALL:     in_lock = 1'b1;
      default:      in_lock = 1'b1;
    endcase
  end

endmodule

// File: rtl/blocklock_policy.sv
module blocklock_policy
  import blocklock_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pin,
  input  logic [REG_W-1:0]  cur,
  input  logic              in_lock,
  output logic              reg_target,
  output verdict_t          verdict
);

  localparam logic [ADDR_W-1:0] REG_ADDR = '1;

  logic is_frozen;
  logic latch_set;

  assign reg_target = (addr == REG_ADDR);
  assign is_frozen  = frozen(pin, cur);
  assign latch_set  = latch_of(cur);

  always_comb begin
    verdict = '0;
    if (req) begin
      if (reg_target) begin
        verdict.reg_ok = ~is_frozen;
        verdict.refuse = is_frozen;
      end else begin
        verdict.arr_ok = latch_set & ~in_lock;
        verdict.refuse = ~(latch_set & ~in_lock);
      end
    end
  end

endmodule

// File: rtl/blocklock_preg.sv
module blocklock_preg
  import blocklock_pkg::*;
#(
  parameter logic [REG_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [REG_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= clean_reg(INIT_VAL);
    else if (load) q <= clean_reg(din);
  end

  assert_clean_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP_MASK) == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/blocklock_guard.sv
module blocklock_guard
  import blocklock_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter logic [REG_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              wp_pin,
  output logic              arr_wr_ok,
  output logic              wr_reject,
  output logic [REG_W-1:0]  prot_reg
);

  logic     locked_hit;
  logic     reg_target;
  verdict_t verdict;

  blocklock_region #(.ADDR_W(ADDR_W)) u_region (
    .addr    (wr_addr),
    .code    (lock_of(prot_reg)),
    .in_lock (locked_hit)
  );

  blocklock_policy #(.ADDR_W(ADDR_W)) u_policy (
    .req        (wr_req),
    .addr       (wr_addr),
    .pin        (wp_pin),
    .cur        (prot_reg),
    .in_lock    (locked_hit),
    .reg_target (reg_target),
    .verdict    (verdict)
  );

  blocklock_preg #(.INIT_VAL(INIT_VAL)) u_preg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (verdict.reg_ok),
    .din   (wr_data),
    .q     (prot_reg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_wr_ok <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      arr_wr_ok <= verdict.arr_ok;
      wr_reject <= verdict.refuse;
    end
  end

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wr_ok && wr_reject));

  assert_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !(arr_wr_ok || wr_reject));

  assert_latch_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> $past(prot_reg[LATCH_B]));

  assert_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_ok |-> !$past(locked_hit));

  assert_reg_not_array_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && reg_target) |=> !arr_wr_ok);

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_pin && prot_reg[HWEN_B]) |=> $stable(prot_reg));

endmodule

// File: tb/blocklock_guard_test.sv
`timescale 1ns/1ps
module blocklock_guard_test;

  typedef struct {
    logic       ok;
    logic       rej;
    logic [7:0] rv;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wp_pin = 1'b0;
  logic       arr_wr_ok;
  logic       wr_reject;
  logic [7:0] prot_reg;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic [7:0] model = 8'h00;
  bit   done = 0;

  always #2.5 clk = ~clk;

  blocklock_guard uut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_pin(wp_pin), .arr_wr_ok(arr_wr_ok),
    .wr_reject(wr_reject), .prot_reg(prot_reg)
  );

  function automatic logic model_locked(input logic [11:0] a, input logic [1:0] code);
    case (code)
      2'd0: return 1'b0;
      2'd1: return a >= 12'd3072;
      2'd2: return a >= 12'd2048;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step(input logic req, input logic [11:0] a, input logic [7:0] d,
                      input logic pin, input string tag);
    exp_t e;
    @(negedge clk);
    wr_req = req; wr_addr = a; wr_data = d; wp_pin = pin;
    e.ok = 1'b0; e.rej = 1'b0; e.tag = tag;
    if (req) begin
      if (a == 12'hFFF) begin
        if (pin && model[7]) e.rej = 1'b1;
        else model = {d[7], 2'b00, d[4], d[3], 1'b0, d[1], 1'b0};
      end else begin
        e.ok  = model[1] && !model_locked(a, model[4:3]);
        e.rej = !e.ok;
      end
    end
    e.rv = model;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 12'h000, 8'h00, wp_pin, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (arr_wr_ok !== e.ok || wr_reject !== e.rej || prot_reg !== e.rv) begin
        errors++;
        $display("FAIL %s: ok=%b rej=%b reg=%h expected ok=%b rej=%b reg=%h",
                 e.tag, arr_wr_ok, wr_reject, prot_reg, e.ok, e.rej, e.rv);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (prot_reg !== 8'h00 || arr_wr_ok !== 1'b0 || wr_reject !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ok=%b rej=%b reg=%h expected ok=0 rej=0 reg=00",
               arr_wr_ok, wr_reject, prot_reg);
    end
    idle("R9 idle after reset");
    step(1, 12'h100, 8'h55, 0, "R2 array write with latch clear");
    idle("R9 idle after reject");
    step(1, 12'hFFF, 8'hFF, 0, "R5 register load masks to 0x9A");
    step(1, 12'h000, 8'h11, 0, "R3 lock all refuses 0x000");
    step(1, 12'hFFF, 8'h02, 0, "R7 pin low rewrites register with hw-enable set");
    step(1, 12'h000, 8'h22, 0, "R4 grant outside region");
    step(1, 12'hFFE, 8'h23, 0, "R4 grant back-to-back at 0xFFE");
    idle("R9 idle after grant");
    step(1, 12'hFFF, 8'h0A, 0, "R5 lock quarter");
    step(1, 12'hBFF, 8'h33, 0, "R3 quarter below boundary grants");
    step(1, 12'hC00, 8'h34, 0, "R3 quarter at boundary refuses");
    step(1, 12'hFFF, 8'h12, 0, "R5 lock half");
    step(1, 12'h7FF, 8'h44, 0, "R3 half below boundary grants");
    step(1, 12'h800, 8'h45, 0, "R3 half at boundary refuses");
    step(1, 12'hFFF, 8'h9A, 1, "R6 set hw-enable with pin high");
    step(1, 12'hFFF, 8'h02, 1, "R6 frozen register refuses");
    step(1, 12'h000, 8'h01, 1, "R10 refused array write keeps register");
    idle("R9 idle while frozen");
    step(1, 12'hFFF, 8'h00, 0, "R7 pin low unfreezes register write");
    step(1, 12'hFFF, 8'h1A, 0, "R8 lock all with latch");
    step(1, 12'hFFF, 8'h18, 0, "R8 clear latch under lock all");
    step(1, 12'h000, 8'h00, 0, "R2 latch cleared refuses");
    step(1, 12'hFFF, 8'h1A, 0, "R8 set latch under lock all");
    step(1, 12'h7FF, 8'h00, 0, "R3 lock all refuses low half");
    idle("R9 final idle");
    idle("R9 final idle 2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule